// File: doc/BRIEF.md
# Prioritised Interrupt Claim Controller

This block gathers interrupt requests from a set of peripheral source lines and presents a single interrupt request to one processor core. A rising edge on a source line marks that source as pending, but only if software has enabled it. Each source carries a small programmable priority. A threshold register masks every source whose priority does not exceed it. The core interrupt output is high whenever at least one source is pending, enabled and above the threshold.

Software services an interrupt by reading the claim register, which returns the identifier of the best eligible source. Reading does not change any state. When the handler finishes, software writes the same identifier back to the claim register, and that write is what retires the source. The next best source then appears in the claim register. Identifier 0 is reserved and means "nothing to service". Pending and enable state each fit in one 32-bit word, so the source count is at most 32. Registers are accessed over a plain single-cycle 32-bit read/write bus with a byte offset and combinational read data.

Top module: `plic_top`

## Requirements
- R1: The byte offsets are: priority of source N at 4·N, pending word at 0x1000, enable word at 0x2000, threshold at 0x200000, claim/complete at 0x200004. Priority and threshold keep their low 3 bits and read back zero-extended.
- R2: Source 0 is reserved. Bit 0 of the pending and enable words always reads 0, and the priority slot of source 0 always reads 0.
- R3: A rising edge on a source line whose enable bit is clear leaves the pending word and the core interrupt unchanged.
- R4: A rising edge on an enabled source sets its pending bit (bit N for source N) at the next clock. `irq_o` is high exactly when some pending, enabled source has priority above the threshold.
- R5: A claim read returns the ID of the eligible source with the largest priority, or 0 if there is none. A claim read never clears a pending bit.
- R6: Writing a nonzero source ID to claim/complete clears that source's pending bit. The next best source then becomes the claim result.
- R7: Among eligible sources of equal priority, the lowest ID is returned.
- R8: Only sources whose priority is strictly greater than the threshold are eligible.
- R9: A source with priority 0 may become pending, but it is never claimed and never raises `irq_o`.
- R10: Synchronous reset clears all priorities, enables, pending bits and the threshold.
- R11: A line held high is captured once. After its completion the pending bit stays clear until the line falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt source lines, bit N is source N |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The assertions assume that source lines and bus signals change only away from the rising clock edge. They also assume that a completion write carries an ID within the source range. The bench drives every input on the falling edge. It only ever writes IDs between 1 and NUM_SRC-1 to the claim register, except when it deliberately writes to source 0's priority slot. The edge-capture check assumes that reset starts with all source lines low, and the bench holds `src_i` at zero throughout each reset.

// File: rtl/plic_pkg.sv
package plic_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 22;

    localparam logic [ADDR_W-1:0] OFF_PEND  = 22'h001000;
    localparam logic [ADDR_W-1:0] OFF_EN    = 22'h002000;
    localparam logic [ADDR_W-1:0] OFF_THR   = 22'h200000;
    localparam logic [ADDR_W-1:0] OFF_CLAIM = 22'h200004;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } region_e;

    function automatic region_e decode_region(input logic [ADDR_W-1:0] addr);
        region_e r;
        r = RG_NONE;
        if (addr[ADDR_W-1:12] == '0 && addr[1:0] == 2'b00) r = RG_PRIO;
        else if (addr == OFF_PEND)  r = RG_PEND;
        else if (addr == OFF_EN)    r = RG_EN;
        else if (addr == OFF_THR)   r = RG_THR;
        else if (addr == OFF_CLAIM) r = RG_CLAIM;
        return r;
    endfunction

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
    parameter int NUM_SRC = 32,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               clr_valid_i,
    input  logic [ID_W-1:0]    clr_id_i,
    output logic [NUM_SRC-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] src;
        logic [NUM_SRC-1:0] pend;
    } gw_t;

    gw_t                st_d, st_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] clr_vec;

    always_comb begin
        rise    = src_i & ~st_q.src;
        clr_vec = '0;
        if (clr_valid_i) clr_vec[clr_id_i] = 1'b1;
        st_d.src  = src_i;
        // a new edge in the same cycle as its completion keeps the bit set
        st_d.pend = (st_q.pend & ~clr_vec) | (rise & en_i);
        st_d.pend[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (rst)
        (clr_valid_i && !rise[clr_id_i]) |=> !pend_o[$past(clr_id_i)]); // R6

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (rst)
                (!en_i[g] && !pend_o[g]) |=> !pend_o[g]); // R3
            AST_HELD_ONCE: assert property (@(posedge clk) disable iff (rst)
                (src_i[g] && $past(src_i[g]) && !pend_o[g]) |=> !pend_o[g]); // R11
        end
    endgenerate

endmodule

// File: rtl/plic_regs.sv
module plic_regs
    import plic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [BUS_W-1:0]               wdata_i,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
    output logic [NUM_SRC-1:0]             en_o,
    output logic [PRIO_W-1:0]              thr_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_SRC-1:0]             en;
        logic [PRIO_W-1:0]              thr;
    } cfg_t;

    localparam logic [NUM_SRC-1:0] EN_MASK = {{(NUM_SRC-1){1'b1}}, 1'b0};

    cfg_t       st_d, st_q;
    region_e    region;
    logic [9:0] slot;

    always_comb begin
        region = decode_region(addr_i);
        slot   = addr_i[11:2];
        st_d   = st_q;
        if (wr_i) begin
            case (region)
                RG_PRIO: if (slot != 10'd0 && slot < 10'(NUM_SRC))
                             st_d.prio[slot[ID_W-1:0]] = wdata_i[PRIO_W-1:0];
                RG_EN:   st_d.en  = wdata_i[NUM_SRC-1:0] & EN_MASK;
                RG_THR:  st_d.thr = wdata_i[PRIO_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign prio_o = st_q.prio;
    assign en_o   = st_q.en;
    assign thr_o  = st_q.thr;

    AST_SLOT0_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (prio_o[0] == '0) && !en_o[0]); // R2

endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0]             en_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]              thr_i,
    output logic [ID_W-1:0]                best_id_o
);

    logic [PRIO_W-1:0] best_p;

    always_comb begin
        best_id_o = '0;
        best_p    = thr_i;
        // strict compare: threshold masks equals, earlier ID keeps ties
        for (int i = 1; i < NUM_SRC; i++) begin
            if (pend_i[i] && en_i[i] && (prio_i[i] > best_p)) begin
                best_id_o = ID_W'(i);
                best_p    = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/plic_top.sv
module plic_top
    import plic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic                irq_o
);

    localparam int ID_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic [NUM_SRC-1:0]             en;
    logic [NUM_SRC-1:0]             pend;
    logic [PRIO_W-1:0]              thr;
    logic [ID_W-1:0]                claim_id;
    logic                           wr;
    logic                           clr_valid;
    region_e                        region;
    logic [9:0]                     slot;

    always_comb begin
        region    = decode_region(bus_addr);
        slot      = bus_addr[11:2];
        wr        = bus_sel && bus_wr;
        clr_valid = wr && (region == RG_CLAIM) && (bus_wdata != '0)
                    && (bus_wdata < BUS_W'(NUM_SRC));
        bus_rdata = '0;
        case (region)
            RG_PRIO:  if (slot < 10'(NUM_SRC)) bus_rdata = BUS_W'(prio[slot[ID_W-1:0]]);
            RG_PEND:  bus_rdata = BUS_W'(pend);
            RG_EN:    bus_rdata = BUS_W'(en);
            RG_THR:   bus_rdata = BUS_W'(thr);
            RG_CLAIM: bus_rdata = BUS_W'(claim_id);
            default:  ;
        endcase
    end

    plic_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .prio_o  (prio),
        .en_o    (en),
        .thr_o   (thr)
    );

    plic_gateway #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_gateway (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src_i),
        .en_i        (en),
        .clr_valid_i (clr_valid),
        .clr_id_i    (bus_wdata[ID_W-1:0]),
        .pend_o      (pend)
    );

    plic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .pend_i    (pend),
        .en_i      (en),
        .prio_i    (prio),
        .thr_i     (thr),
        .best_id_o (claim_id)
    );

    assign irq_o = (claim_id != '0);

    AST_CLAIM_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        (claim_id != '0) |-> (pend[claim_id] && en[claim_id] && (prio[claim_id] > thr))); // R8
    AST_CLAIM_NONZERO_PRIO: assert property (@(posedge clk) disable iff (rst)
        (claim_id != '0) |-> (prio[claim_id] != '0)); // R9
    AST_ID0_NOT_PENDING: assert property (@(posedge clk) disable iff (rst)
        !pend[0]); // R2
    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((pend & en) != '0)); // R4
    AST_READ_KEEPS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && region == RG_CLAIM) |=> ((pend & $past(pend)) == $past(pend))); // R5

endmodule

// File: tb/plic_top_bench.sv
module plic_top_bench;
    import plic_pkg::*;

    localparam int NSRC = 32;
    localparam int NV   = 39;
    // entry: {op[3:0], req[3:0], addr[23:0], val[31:0]}
    // op 1 = bus write, 2 = bus read check, 3 = pulse source val, 4 = irq check
    localparam logic [63:0] TBL [NV] = '{
        {4'd3, 4'd3, 24'h000000, 32'd2},        // R3 pulse disabled source
        {4'd2, 4'd3, 24'h001000, 32'h0},
        {4'd2, 4'd3, 24'h200004, 32'h0},
        {4'd4, 4'd3, 24'h000000, 32'h0},
        {4'd1, 4'd1, 24'h000004, 32'h1},        // R1 priority source 1
        {4'd2, 4'd1, 24'h000004, 32'h1},
        {4'd1, 4'd1, 24'h002000, 32'h2},
        {4'd3, 4'd4, 24'h000000, 32'd1},        // R4
        {4'd2, 4'd4, 24'h001000, 32'h2},
        {4'd4, 4'd4, 24'h000000, 32'h1},
        {4'd2, 4'd5, 24'h200004, 32'h1},        // R5
        {4'd2, 4'd5, 24'h001000, 32'h2},
        {4'd1, 4'd6, 24'h200004, 32'h1},        // R6
        {4'd2, 4'd6, 24'h001000, 32'h0},
        {4'd2, 4'd6, 24'h200004, 32'h0},
        {4'd4, 4'd6, 24'h000000, 32'h0},
        {4'd1, 4'd5, 24'h000004, 32'h3},
        {4'd1, 4'd5, 24'h000008, 32'h2},
        {4'd1, 4'd5, 24'h00000C, 32'h1},
        {4'd1, 4'd5, 24'h002000, 32'hE},
        {4'd3, 4'd5, 24'h000000, 32'd1},
        {4'd3, 4'd5, 24'h000000, 32'd2},
        {4'd3, 4'd5, 24'h000000, 32'd3},
        {4'd2, 4'd5, 24'h001000, 32'hE},
        {4'd2, 4'd5, 24'h200004, 32'h1},
        {4'd1, 4'd6, 24'h200004, 32'h1},
        {4'd2, 4'd6, 24'h001000, 32'hC},
        {4'd2, 4'd6, 24'h200004, 32'h2},
        {4'd1, 4'd6, 24'h200004, 32'h2},
        {4'd2, 4'd6, 24'h001000, 32'h8},
        {4'd2, 4'd6, 24'h200004, 32'h3},
        {4'd4, 4'd6, 24'h000000, 32'h1},
        {4'd1, 4'd6, 24'h200004, 32'h3},
        {4'd2, 4'd6, 24'h001000, 32'h0},
        {4'd2, 4'd6, 24'h200004, 32'h0},
        {4'd4, 4'd6, 24'h000000, 32'h0},
        {4'd1, 4'd8, 24'h200000, 32'h5},        // R8 threshold readback
        {4'd2, 4'd8, 24'h200000, 32'h5},
        {4'd1, 4'd8, 24'h200000, 32'h0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSRC-1:0]   src = '0;
    logic              sel = 1'b0;
    logic              wrn = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq;
    int                total = 0;
    int                bad = 0;
    bit                done = 1'b0;

    always #2 clk = ~clk;

    plic_top #(.NUM_SRC(NSRC), .PRIO_W(3)) u_plic_top (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src),
        .bus_sel   (sel),
        .bus_wr    (wrn),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wrn = 1'b1; addr = a[ADDR_W-1:0]; wdata = d;
        @(negedge clk);
        sel = 1'b0; wrn = 1'b0;
    endtask

    task automatic bus_read(input logic [23:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wrn = 1'b0; addr = a[ADDR_W-1:0];
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [23:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic irq_check(input string req, input logic exp);
        @(negedge clk);
        #1 check(req, 32'(irq), 32'(exp));
    endtask

    task automatic pulse(input int id);
        @(negedge clk); src[id] = 1'b1;
        @(negedge clk); src[id] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; src = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_cleared(input string req);
        read_check(req, 24'h000004, 32'h0);
        read_check(req, 24'h000014, 32'h0);
        read_check(req, 24'h000024, 32'h0);
        read_check(req, 24'h001000, 32'h0);
        read_check(req, 24'h002000, 32'h0);
        read_check(req, 24'h200000, 32'h0);
        read_check(req, 24'h200004, 32'h0);
        irq_check(req, 1'b0);
    endtask

    initial begin
        do_reset();
        check_cleared("R10 initial");

        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d step %0d", TBL[k][59:56], k);
            case (TBL[k][63:60])
                4'd1: bus_write(TBL[k][55:32], TBL[k][31:0]);
                4'd2: read_check(tag, TBL[k][55:32], TBL[k][31:0]);
                4'd3: pulse(int'(TBL[k][31:0]));
                4'd4: irq_check(tag, TBL[k][0]);
                default: ;
            endcase
        end

        // R1 priority keeps 3 bits
        bus_write(24'h000014, 32'hFFFF_FFFF);
        read_check("R1 prio zero-extend", 24'h000014, 32'h7);
        // R2 reserved source 0
        bus_write(24'h000000, 32'h7);
        read_check("R2 prio slot 0", 24'h000000, 32'h0);
        bus_write(24'h002000, 32'hFFFF_FFFF);
        read_check("R2 enable bit 0", 24'h002000, 32'hFFFF_FFFE);
        bus_write(24'h002000, 32'h0);

        // R7 tie: sources 4 and 6 at priority 2
        bus_write(24'h000010, 32'h2);
        bus_write(24'h000018, 32'h2);
        bus_write(24'h002000, 32'h50);
        pulse(6);
        pulse(4);
        read_check("R7 tie lower id", 24'h200004, 32'h4);
        read_check("R5 claim stable", 24'h200004, 32'h4);
        read_check("R5 pending kept", 24'h001000, 32'h50);

        // R8 threshold strict
        bus_write(24'h200000, 32'h2);
        read_check("R8 equal masked", 24'h200004, 32'h0);
        irq_check("R8 irq masked", 1'b0);
        bus_write(24'h200000, 32'h1);
        read_check("R8 above thr", 24'h200004, 32'h4);
        irq_check("R8 irq unmasked", 1'b1);
        bus_write(24'h200004, 32'h4);
        read_check("R6 next best", 24'h200004, 32'h6);
        bus_write(24'h200004, 32'h6);
        read_check("R6 drained", 24'h200004, 32'h0);
        bus_write(24'h200000, 32'h0);

        // R9 priority zero source
        bus_write(24'h002000, 32'h400);
        pulse(10);
        read_check("R9 pending set", 24'h001000, 32'h400);
        read_check("R9 not claimed", 24'h200004, 32'h0);
        irq_check("R9 no irq", 1'b0);
        bus_write(24'h200004, 32'd10);
        read_check("R9 cleared", 24'h001000, 32'h0);

        // R11 line held high
        bus_write(24'h000024, 32'h1);
        bus_write(24'h002000, 32'h200);
        @(negedge clk); src[9] = 1'b1;
        read_check("R11 captured", 24'h001000, 32'h200);
        bus_write(24'h200004, 32'd9);
        repeat (3) @(negedge clk);
        read_check("R11 not recaptured", 24'h001000, 32'h0);
        irq_check("R11 irq low", 1'b0);
        @(negedge clk); src[9] = 1'b0;
        pulse(9);
        read_check("R11 new edge", 24'h200004, 32'd9);

        // R10 reset mid-run
        do_reset();
        check_cleared("R10 mid-run");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule